// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the byte-level engine of an I2C target with a 7-bit address. It samples SDA and SCL through synchronisers and recognises START and STOP. It shifts bytes in on rising SCL edges and shifts bytes out on falling SCL edges. It answers with ACK on the ninth clock. Software reaches it through one byte-wide buffer, a buffer-full flag, an overflow flag and a sticky per-byte interrupt flag. All of these are driven by simple read and write strobes.

The engine holds SCL low through an open-drain enable to give software time to react. After a receive byte, holding is optional and governed by an enable input. After a transmit slot, holding is always armed. The decision is taken at the falling edge of the ninth clock, from the buffer state at that moment. A software-owned release bit ends the hold. The engine only drives SCL low after it has seen the line low, and letting go of SCL never overrides another device that is still holding the line low.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, scl_oe and sda_oe are low, buf_full, overflow and irq are low, and release_bit is high.
- R2: The first byte after START carries the address in bits 7:1, MSB first, and the direction in bit 0 (1 = target transmits). A matching address is acknowledged by driving SDA low for the whole ninth clock. A non-matching address leaves SDA released for the rest of the transfer.
- R3: A received data byte is taken MSB first. It is placed in the buffer at the falling edge of the eighth clock, and buf_full is set. A rd_stb pulse clears buf_full, and rd_data shows the buffer.
- R4: If a received byte completes while buf_full is still set, overflow is set, no ACK is driven, and the buffer keeps its earlier byte. ovf_clr clears overflow.
- R5: irq is set at the falling edge of the ninth clock of every byte in an addressed transfer. It stays set until irq_clr.
- R6: In a receive transfer with rx_hold_en high, if buf_full is set at the ninth falling edge, release_bit is cleared and SCL is held low.
- R7: In a receive transfer, no hold occurs if buf_full was cleared by a read before the ninth falling edge, or if rx_hold_en is low.
- R8: In a transmit transfer (after a read address, or after a byte the controller acknowledged), an empty buffer at the ninth falling edge clears release_bit and holds SCL, whatever rx_hold_en is. A byte written during the hold is then sent MSB first.
- R9: If the transmit buffer was written before the ninth falling edge, no hold occurs. The byte moves to the shifter, and buf_full clears.
- R10: release_set raises release_bit in the next cycle whatever buf_full is. scl_oe only goes high when the synchronised SCL was already low.
- R11: Once release_bit is high, scl_oe drops. SCL then rises only when every other device holding it low has let go.
- R12: START returns the engine to address reception. STOP, or a controller NACK after a transmitted byte, returns it to idle, where clocked bits are ignored and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| own_addr | input | 7 | Target address |
| rx_hold_en | input | 1 | Enable holding after received bytes |
| wr_stb | input | 1 | Write buffer strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Read buffer strobe (clears buf_full) |
| rd_data | output | 8 | Buffer contents |
| release_set | input | 1 | Software sets the release bit |
| ovf_clr | input | 1 | Clear overflow flag |
| irq_clr | input | 1 | Clear interrupt flag |
| irq | output | 1 | Per-byte interrupt flag |
| buf_full | output | 1 | Buffer holds an unconsumed byte |
| overflow | output | 1 | Received byte lost to a full buffer |
| release_bit | output | 1 | High: SCL not held by this engine |
| tx_mode | output | 1 | Engine is in a transmit transfer |

## Verification
Some properties are checked by assertions on every cycle:
- scl_oe never rises unless the synchronised SCL was low in the cycle before, and it always falls once the release bit is set.
- A release strobe always takes effect.
- The interrupt flag only rises after a detected SCL fall.
- Idle never drives SDA.
- A pending transmit load completes as soon as data arrives.

Other behaviour can only be shown by the bench's transfers:
- Whether a hold happens at all depends on what software did before the ninth falling edge.
- Acknowledge across the whole address space.
- Overflow retention of the old byte.
- The wired-AND release with a second holder.
- The exact bit order on SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_RX   = 2'd2,
      PH_TX   = 2'd3
   } phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int          WIDTH     = 2,
   parameter int          STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stg_q[i] <= RESET_VAL;
         else if (i == 0) stg_q[i] <= d;
         else             stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_edges.sv
module i2cs_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic ev_rise,
   output logic ev_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign ev_rise  = scl_s & ~scl_d;
   assign ev_fall  = ~scl_s & scl_d;
   assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
   assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_scl_hold.sv
module i2cs_scl_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic hw_hold,
   input  logic release_set,
   output logic rel_q,
   output logic scl_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q  <= 1'b1;
         scl_oe <= 1'b0;
      end else begin
         if (release_set)  rel_q <= 1'b1;
         else if (hw_hold) rel_q <= 1'b0;
         if (rel_q)        scl_oe <= 1'b0;
         else if (!scl_s)  scl_oe <= 1'b1;
      end
   end

   // R10
   scl_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(!scl_s));
   // R11
   release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |=> !scl_oe);
   // R10
   sw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_set |=> rel_q);
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
   import i2cs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              rx_hold_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   input  logic              release_set,
   input  logic              ovf_clr,
   input  logic              irq_clr,
   output logic              irq,
   output logic              buf_full,
   output logic              overflow,
   output logic              release_bit,
   output logic              tx_mode
);
   localparam int CNT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(DATA_W + 1);

   if (DATA_W != ADDR_W + 1 || DATA_W < 2) begin : g_bad_width
      $error("i2c_target_stretch: DATA_W must equal ADDR_W+1 and be at least 2");
   end

   logic [1:0] line_s;
   logic scl_s, sda_s;
   logic ev_rise, ev_fall, ev_start, ev_stop;

   i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s));
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   i2cs_edges u_edges (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop));

   phase_t            phase_q;
   logic [CNT_W-1:0]  bitcnt_q;
   logic [DATA_W-1:0] shreg_q, buf_q;
   logic              buf_full_q, ovf_q, irq_q, sda_drv_q;
   logic              rd_dir_q, mnack_q, tx_wait_q, hw_hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         bitcnt_q   <= '0;
         shreg_q    <= '0;
         buf_q      <= '0;
         buf_full_q <= 1'b0;
         ovf_q      <= 1'b0;
         irq_q      <= 1'b0;
         sda_drv_q  <= 1'b0;
         rd_dir_q   <= 1'b0;
         mnack_q    <= 1'b0;
         tx_wait_q  <= 1'b0;
         hw_hold_q  <= 1'b0;
      end else begin
         hw_hold_q <= 1'b0;
         if (wr_stb) begin
            buf_q      <= wr_data;
            buf_full_q <= 1'b1;
         end else if (rd_stb) begin
            buf_full_q <= 1'b0;
         end
         if (ovf_clr) ovf_q <= 1'b0;
         if (irq_clr) irq_q <= 1'b0;

         if (ev_start) begin
            phase_q   <= PH_ADDR;
            bitcnt_q  <= '0;
            sda_drv_q <= 1'b0;
            tx_wait_q <= 1'b0;
         end else if (ev_stop) begin
            phase_q   <= PH_IDLE;
            bitcnt_q  <= '0;
            sda_drv_q <= 1'b0;
            tx_wait_q <= 1'b0;
         end else if (tx_wait_q) begin
            if (buf_full_q) begin
               shreg_q    <= buf_q;
               buf_full_q <= 1'b0;
               sda_drv_q  <= ~buf_q[DATA_W-1];
               tx_wait_q  <= 1'b0;
            end
         end else if (phase_q != PH_IDLE) begin
            if (ev_rise) begin
               if (bitcnt_q < LAST_CNT) begin
                  bitcnt_q <= bitcnt_q + 1'b1;
                  if (phase_q != PH_TX) shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
               end else if (bitcnt_q == ACK_CNT) begin
                  mnack_q <= sda_s;
               end
            end else if (ev_fall) begin
               if (bitcnt_q == LAST_CNT) begin
                  bitcnt_q <= ACK_CNT;
                  case (phase_q)
                     PH_ADDR: begin
                        if (shreg_q[DATA_W-1:1] == own_addr) begin
                           sda_drv_q <= 1'b1;
                           rd_dir_q  <= shreg_q[0];
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     PH_RX: begin
                        if (buf_full_q) begin
                           ovf_q <= 1'b1;
                        end else begin
                           buf_q      <= shreg_q;
                           buf_full_q <= 1'b1;
                           sda_drv_q  <= 1'b1;
                        end
                     end
                     default: sda_drv_q <= 1'b0;
                  endcase
               end else if (bitcnt_q == ACK_CNT) begin
                  bitcnt_q  <= '0;
                  sda_drv_q <= 1'b0;
                  irq_q     <= 1'b1;
                  if (phase_q == PH_RX) begin
                     hw_hold_q <= rx_hold_en & buf_full_q;
                  end else if (phase_q == PH_ADDR && !rd_dir_q) begin
                     phase_q <= PH_RX;
                  end else if (phase_q == PH_TX && mnack_q) begin
                     phase_q <= PH_IDLE;
                  end else begin
                     phase_q <= PH_TX;
                     if (buf_full_q) begin
                        shreg_q    <= buf_q;
                        buf_full_q <= 1'b0;
                        sda_drv_q  <= ~buf_q[DATA_W-1];
                     end else begin
                        tx_wait_q <= 1'b1;
                        hw_hold_q <= 1'b1;
                     end
                  end
               end else if (phase_q == PH_TX && bitcnt_q != '0) begin
                  shreg_q   <= {shreg_q[DATA_W-2:0], 1'b0};
                  sda_drv_q <= ~shreg_q[DATA_W-2];
               end
            end
         end
      end
   end

   i2cs_scl_hold u_hold (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .hw_hold(hw_hold_q),
      .release_set(release_set), .rel_q(release_bit), .scl_oe(scl_oe));

   assign sda_oe   = sda_drv_q;
   assign rd_data  = buf_q;
   assign buf_full = buf_full_q;
   assign overflow = ovf_q;
   assign irq      = irq_q;
   assign tx_mode  = (phase_q == PH_TX);

   // R5
   irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(ev_fall));
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !sda_drv_q);
   // R8
   tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wait_q && buf_full_q) |=> (!tx_wait_q && !buf_full_q));
endmodule

// File: tb/i2c_target_stretch_test.sv
module i2c_target_stretch_test;
   localparam int Q = 8;
   localparam logic [6:0] OWN = 7'h2C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1, scl_ext = 1'b0;
   logic scl_oe, sda_oe, scl_line, sda_line;
   logic rx_hold_en = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic release_set = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
   logic [7:0] wr_data = 8'h00, rd_data;
   logic irq, buf_full, overflow, release_bit, tx_mode;

   assign scl_line = scl_m & ~scl_oe & ~scl_ext;
   assign sda_line = sda_m & ~sda_oe;

   i2c_target_stretch uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .rx_hold_en(rx_hold_en),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
      .release_set(release_set), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
      .irq(irq), .buf_full(buf_full), .overflow(overflow),
      .release_bit(release_bit), .tx_mode(tx_mode));

   int tests = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic bus_start;
      sda_m = 1'b1; waitc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      waitc(Q); sda_m = 1'b0; waitc(Q);
      scl_m = 1'b0; waitc(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; waitc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      waitc(Q); sda_m = 1'b1; waitc(Q);
   endtask

   task automatic put_bit(input logic b, output logic s);
      sda_m = b; waitc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      waitc(Q); s = sda_line; waitc(Q);
      scl_m = 1'b0; waitc(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(d[i], s);
      put_bit(1'b1, ack);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         put_bit(1'b1, s);
         d[i] = s;
      end
      put_bit(mack, s);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic ack, s;
      logic [7:0] d;
      waitc(4);
      rst_n = 1'b1;
      waitc(4);
      // R1 reset state
      chk(scl_oe == 0 && sda_oe == 0, "R1 drives", {scl_oe, sda_oe}, 0);
      chk(buf_full == 0 && overflow == 0 && irq == 0, "R1 flags", {buf_full, overflow, irq}, 0);
      chk(release_bit == 1, "R1 release", release_bit, 1);

      // R2 sweep every address, write direction
      for (int a = 0; a < 128; a++) begin
         bus_start;
         send_byte({a[6:0], 1'b0}, ack);
         chk(ack == (a[6:0] != OWN), "R2 address ack", ack, (a[6:0] != OWN));
         bus_stop;
         pulse(irq_clr);
      end
      chk(buf_full == 0, "R2 address not buffered", buf_full, 0);

      // R3 R4 R5 R7: receive with holding disabled
      rx_hold_en = 1'b0;
      bus_start;
      send_byte({OWN, 1'b0}, ack);
      chk(irq == 1, "R5 irq after address", irq, 1);
      pulse(irq_clr);
      chk(irq == 0, "R5 irq clear", irq, 0);
      send_byte(8'hA5, ack);
      chk(ack == 0, "R3 data ack", ack, 0);
      chk(buf_full == 1 && rd_data == 8'hA5, "R3 data in buffer", rd_data, 8'hA5);
      chk(irq == 1, "R5 irq after data", irq, 1);
      chk(release_bit == 1 && scl_oe == 0, "R7 no hold when disabled", release_bit, 1);
      send_byte(8'h3C, ack);
      chk(ack == 1, "R4 overflow nack", ack, 1);
      chk(overflow == 1, "R4 overflow flag", overflow, 1);
      chk(rd_data == 8'hA5, "R4 buffer kept", rd_data, 8'hA5);
      bus_stop;
      pulse(rd_stb);
      chk(buf_full == 0, "R3 read clears full", buf_full, 0);
      pulse(ovf_clr); pulse(irq_clr);
      chk(overflow == 0, "R4 overflow clear", overflow, 0);

      // R6 R10 R11 R7: receive with holding enabled
      rx_hold_en = 1'b1;
      bus_start;
      send_byte({OWN, 1'b0}, ack);
      chk(release_bit == 1, "R6 no hold after write address", release_bit, 1);
      send_byte(8'h96, ack);
      sda_m = 1'b0;            // first bit of next byte 0x69
      scl_m = 1'b1;
      waitc(3 * Q);
      chk(scl_line == 0 && scl_oe == 1, "R6 SCL held", scl_line, 0);
      chk(release_bit == 0, "R6 release cleared", release_bit, 0);
      scl_ext = 1'b1;
      pulse(release_set);
      waitc(2);
      chk(release_bit == 1 && buf_full == 1, "R10 release while full", {release_bit, buf_full}, 3);
      waitc(Q);
      chk(scl_oe == 0 && scl_line == 0, "R11 other holder keeps low", {scl_oe, scl_line}, 0);
      chk(rd_data == 8'h96, "R3 first byte", rd_data, 8'h96);
      pulse(rd_stb);
      scl_ext = 1'b0;
      waitc(2);
      chk(scl_line == 1, "R11 line rises after all release", scl_line, 1);
      waitc(Q); scl_m = 1'b0; waitc(Q);
      for (int i = 6; i >= 0; i--) put_bit(logic'((8'h69 >> i) & 1), s);
      sda_m = 1'b1; waitc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      waitc(2);
      d = rd_data;
      pulse(rd_stb);
      waitc(Q); ack = sda_line; waitc(Q);
      scl_m = 1'b0; waitc(Q);
      chk(ack == 0 && d == 8'h69, "R3 second byte", d, 8'h69);
      chk(release_bit == 1 && scl_oe == 0, "R7 read before ninth fall", release_bit, 1);
      bus_stop;
      pulse(irq_clr);

      // R8 R9 R12: transmit
      rx_hold_en = 1'b0;
      bus_start;
      send_byte({OWN, 1'b1}, ack);
      chk(ack == 0 && tx_mode == 1, "R8 read address", {ack, tx_mode}, 1);
      sda_m = 1'b1;
      scl_m = 1'b1;
      waitc(3 * Q);
      chk(scl_line == 0 && release_bit == 0, "R8 held on empty buffer", release_bit, 0);
      wr_data = 8'hC3; pulse(wr_stb);
      waitc(2);
      pulse(release_set);
      while (!scl_line) @(negedge clk);
      waitc(Q); d[7] = sda_line; waitc(Q);
      scl_m = 1'b0; waitc(Q);
      for (int i = 6; i >= 1; i--) begin
         put_bit(1'b1, s); d[i] = s;
      end
      put_bit(1'b1, s); d[0] = s;
      chk(d == 8'hC3, "R8 byte sent MSB first", d, 8'hC3);
      sda_m = 1'b0; waitc(Q);
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      wr_data = 8'h5E; pulse(wr_stb);
      waitc(Q);
      scl_m = 1'b0; waitc(Q);
      chk(release_bit == 1 && scl_oe == 0, "R9 no hold when preloaded", release_bit, 1);
      chk(buf_full == 0, "R9 buffer moved to shifter", buf_full, 0);
      recv_byte(1'b1, d);
      chk(d == 8'h5E, "R9 preloaded byte", d, 8'h5E);
      chk(tx_mode == 0 && sda_oe == 0 && scl_oe == 0, "R12 nack to idle", {tx_mode, sda_oe, scl_oe}, 0);
      bus_stop;
      pulse(irq_clr);

      // R12: STOP mid-address, clocking while idle, START again
      bus_start;
      for (int i = 7; i >= 4; i--) put_bit(logic'((8'h58 >> i) & 1), s);
      bus_stop;
      scl_m = 1'b0; waitc(Q);
      send_byte({OWN, 1'b0}, ack);
      chk(ack == 1, "R12 idle ignores bits", ack, 1);
      bus_start;
      send_byte({OWN, 1'b0}, ack);
      chk(ack == 0, "R12 start restarts address", ack, 0);
      bus_stop;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule